// File: doc/BRIEF.md
# Bank-Aware DRAM Command Sequencer

This block sits between a memory-request source and a DRAM command bus. It takes one request at a time over a valid/ready handshake, with an address and a read/write flag, and turns it into a short run of DRAM commands: precharge, activate, and a column read or write. It keeps a per-bank model of which row each bank holds open. From that model it decides how many of the three access phases the request needs, and it reports a row hit or miss when the request completes.

Before the bank field is used, it is scrambled with the low bits of the cache-tag part of the address. Addresses that would fight over one cache set then land in different banks. A static policy input chooses between two modes. In open-row mode a row stays open after an access and later requests to it go straight to the column phase. In closed-row mode every column command carries an auto-precharge flag and the bank is released. Minimum gaps from precharge to activate and from activate to column are parameters, and a countdown timer enforces them.

The controller is a six-state machine. IDLE waits for a request. LOOK inspects the target bank. PRE, ACT and COL each issue one command. WAIT holds until the gap timer expires. The transitions are:
- IDLE→LOOK on a handshake.
- LOOK→COL on an open-row hit.
- LOOK→PRE when the bank holds a row that cannot be used.
- LOOK→ACT when the bank is closed.
- PRE→WAIT, or PRE→ACT when the precharge gap is one cycle.
- ACT→WAIT, or ACT→COL when the activate gap is one cycle.
- WAIT→ACT or WAIT→COL on timer expiry.
- COL→IDLE.

Top module: `dram_cmd_seq`

## Requirements
- R1: After reset, `req_ready` is 1, `cmd_valid` and `done` are 0, and every bank is closed, so the first access to any bank issues ACT without PRE and reports a miss.
- R2: `req_ready` is 1 only in IDLE. Exactly one request is accepted per cycle in which `req_valid` and `req_ready` are both 1, and no command is issued while `req_ready` is 1.
- R3: The address splits into column `addr[COL_W-1:0]`, bank field `addr[COL_W +: BANK_W]` and row `addr[ADDR_W-1:COL_W+BANK_W]`. The bank used is the bank field XOR `addr[TAG_LSB +: BANK_W]`, which are the lowest bits of the tag above the cache boundary `TAG_LSB`.
- R4: In open-row mode (`closed_pol`=0), a request to the row open in its bank issues only the column command and completes with `done_hit`=1.
- R5: In open-row mode, a request to a bank holding a different row issues PRE, then ACT, then the column command, with `done_hit`=0.
- R6: A request to a closed bank issues ACT then the column command, with `done_hit`=0.
- R7: In closed-row mode (`closed_pol`=1), the column command has `cmd_autopre`=1, the bank is marked closed afterwards, and `done_hit` is always 0. A bank still open from open-row mode is precharged first.
- R8: Each bank tracks its own open row, so rows open in different banks stay open while other banks are accessed.
- R9: ACT follows PRE after exactly `T_RP` cycles.
- R10: The column command follows ACT after exactly `T_RCD` cycles.
- R11: `done` is a one-cycle pulse in the same cycle as the column command, with `done_hit` valid in that cycle.
- R12: `cmd_op` encodes 0=PRE, 1=ACT, 2=READ, 3=WRITE. `cmd_bank` carries the remapped bank, `cmd_row` carries the row on ACT, and `cmd_col` carries the column on READ and WRITE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| closed_pol | input | 1 | 1 = closed-row policy, 0 = open-row policy (static) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_addr | input | ADDR_W | Request address |
| req_wr | input | 1 | 1 = write, 0 = read |
| cmd_valid | output | 1 | A command is on the bus this cycle |
| cmd_op | output | 2 | Command code |
| cmd_bank | output | BANK_W | Remapped bank |
| cmd_row | output | ROW_W | Row address |
| cmd_col | output | COL_W | Column address |
| cmd_autopre | output | 1 | Auto-precharge on the column command |
| done | output | 1 | Request finished |
| done_hit | output | 1 | Finished request was an open-row hit |

## Verification
The bench builds the block with `T_RP`=4 and `T_RCD`=2. These gaps are unequal and both longer than one cycle, so every WAIT path is exercised and a swapped or off-by-one gap shows up as a wrong cycle distance. The address widths stay at their defaults: a 4-bit column, 4 banks and the tag boundary at bit 10. With these widths the row field overlaps the XOR bits, so changing only the row can move a request to a different bank. Directed sequences cover hits, conflicts, independence between banks and a switch from open-row to closed-row mode with banks left open. A pseudo-random run over a few rows then mixes all of these cases.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
    typedef enum logic [1:0] {
        OP_PRE = 2'd0,
        OP_ACT = 2'd1,
        OP_RD  = 2'd2,
        OP_WR  = 2'd3
    } dcmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOK,
        ST_PRE,
        ST_ACT,
        ST_COL,
        ST_WAIT
    } seq_st_e;
endpackage

// File: rtl/bank_remap.sv
module bank_remap #(
    parameter int ADDR_W  = 20,
    parameter int COL_W   = 4,
    parameter int BANK_W  = 2,
    parameter int TAG_LSB = 10,
    localparam int ROW_W  = ADDR_W - COL_W - BANK_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] bank,
    output logic [ROW_W-1:0]  row,
    output logic [COL_W-1:0]  col
);
    logic [BANK_W-1:0] bank_field;
    logic [BANK_W-1:0] tag_low;

    always_comb begin
        col        = addr[COL_W-1:0];
        bank_field = addr[COL_W +: BANK_W];
        row        = addr[ADDR_W-1 : COL_W+BANK_W];
        tag_low    = addr[TAG_LSB +: BANK_W];
        bank       = bank_field ^ tag_low;
    end
endmodule

// File: rtl/bank_table.sv
module bank_table #(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 14,
    localparam int NBANK = 1 << BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] bank,
    input  logic [ROW_W-1:0]  row,
    input  logic              set_en,
    input  logic              clr_en,
    output logic              is_open,
    output logic              row_match
);
    logic [NBANK-1:0] open_q;
    logic [ROW_W-1:0] row_q [NBANK];

    for (genvar i = 0; i < NBANK; i++) begin : g_bank
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_q[i] <= 1'b0;
                row_q[i]  <= '0;
            end else if (bank == BANK_W'(i)) begin
                if (set_en) begin
                    open_q[i] <= 1'b1;
                    row_q[i]  <= row;
                end else if (clr_en) begin
                    open_q[i] <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        is_open   = open_q[bank];
        row_match = (row_q[bank] == row);
    end

    // An activate only ever targets a bank that is closed
    p_act_closed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |-> !open_q[bank]);
    // A bank is never opened and released in the same cycle
    p_set_clr_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_en && clr_en));
endmodule

// File: rtl/gap_timer.sv
module gap_timer #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] val,
    output logic          last
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q <= CW'(1));

    // A new gap is started only after the previous one has run out
    p_load_expired_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> cnt_q == '0);
endmodule

// File: rtl/dram_cmd_seq.sv
module dram_cmd_seq
    import dram_seq_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int COL_W   = 4,
    parameter int BANK_W  = 2,
    parameter int TAG_LSB = 10,
    parameter int T_RP    = 3,
    parameter int T_RCD   = 2,
    localparam int ROW_W  = ADDR_W - COL_W - BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              closed_pol,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_wr,
    output logic              cmd_valid,
    output logic [1:0]        cmd_op,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_row,
    output logic [COL_W-1:0]  cmd_col,
    output logic              cmd_autopre,
    output logic              done,
    output logic              done_hit
);
    localparam int GAP_MAX = (T_RP > T_RCD) ? T_RP : T_RCD;
    localparam int CW      = $clog2(GAP_MAX + 1);
    localparam int SW      = CW + 1;

    seq_st_e           state_q, state_d;
    logic              tgt_col_q;
    logic              hit_q;
    logic              wr_q;
    logic [BANK_W-1:0] bank_q;
    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  col_q;

    logic [BANK_W-1:0] in_bank;
    logic [ROW_W-1:0]  in_row;
    logic [COL_W-1:0]  in_col;
    logic              tbl_open, tbl_match, tbl_set, tbl_clr;
    logic              tmr_load, tmr_last;
    logic [CW-1:0]     tmr_val;
    logic              look_hit;

    bank_remap #(
        .ADDR_W(ADDR_W), .COL_W(COL_W), .BANK_W(BANK_W), .TAG_LSB(TAG_LSB)
    ) u_remap (
        .addr(req_addr), .bank(in_bank), .row(in_row), .col(in_col)
    );

    bank_table #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_table (
        .clk(clk), .rst_n(rst_n), .bank(bank_q), .row(row_q),
        .set_en(tbl_set), .clr_en(tbl_clr),
        .is_open(tbl_open), .row_match(tbl_match)
    );

    gap_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .val(tmr_val), .last(tmr_last)
    );

    assign look_hit = !closed_pol && tbl_open && tbl_match;

    // State register and request latches
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            tgt_col_q <= 1'b0;
            hit_q     <= 1'b0;
            wr_q      <= 1'b0;
            bank_q    <= '0;
            row_q     <= '0;
            col_q     <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req_valid) begin
                bank_q <= in_bank;
                row_q  <= in_row;
                col_q  <= in_col;
                wr_q   <= req_wr;
            end
            if (state_q == ST_LOOK) hit_q <= look_hit;
            if (state_q == ST_PRE)  tgt_col_q <= 1'b0;
            if (state_q == ST_ACT)  tgt_col_q <= 1'b1;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_LOOK;
            ST_LOOK: begin
                if (look_hit)      state_d = ST_COL;
                else if (tbl_open) state_d = ST_PRE;
                else               state_d = ST_ACT;
            end
            ST_PRE:  state_d = (T_RP  > 1) ? ST_WAIT : ST_ACT;
            ST_ACT:  state_d = (T_RCD > 1) ? ST_WAIT : ST_COL;
            ST_WAIT: if (tmr_last) state_d = tgt_col_q ? ST_COL : ST_ACT;
            ST_COL:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_ready   = 1'b0;
        cmd_valid   = 1'b0;
        cmd_op      = OP_PRE;
        cmd_autopre = 1'b0;
        done        = 1'b0;
        tbl_set     = 1'b0;
        tbl_clr     = 1'b0;
        tmr_load    = 1'b0;
        tmr_val     = '0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_PRE: begin
                cmd_valid = 1'b1;
                cmd_op    = OP_PRE;
                tbl_clr   = 1'b1;
                tmr_load  = (T_RP > 1);
                tmr_val   = CW'(T_RP - 1);
            end
            ST_ACT: begin
                cmd_valid = 1'b1;
                cmd_op    = OP_ACT;
                tbl_set   = 1'b1;
                tmr_load  = (T_RCD > 1);
                tmr_val   = CW'(T_RCD - 1);
            end
            ST_COL: begin
                cmd_valid   = 1'b1;
                cmd_op      = wr_q ? OP_WR : OP_RD;
                cmd_autopre = closed_pol;
                tbl_clr     = closed_pol;
                done        = 1'b1;
            end
            ST_LOOK, ST_WAIT: ;
            default: ;
        endcase
    end

    assign cmd_bank = bank_q;
    assign cmd_row  = row_q;
    assign cmd_col  = col_q;
    assign done_hit = hit_q;

    // Distance counters used only by the gap assertions
    logic [SW-1:0] since_pre_q, since_act_q;
    logic          pre_pend_q, act_pend_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_pre_q <= '0;
            since_act_q <= '0;
            pre_pend_q  <= 1'b0;
            act_pend_q  <= 1'b0;
        end else begin
            if (cmd_valid && cmd_op == OP_PRE) begin
                since_pre_q <= SW'(1);
                pre_pend_q  <= 1'b1;
            end else if (since_pre_q != '1) begin
                since_pre_q <= since_pre_q + 1'b1;
            end
            if (cmd_valid && cmd_op == OP_ACT) begin
                since_act_q <= SW'(1);
                act_pend_q  <= 1'b1;
                pre_pend_q  <= 1'b0;
            end else if (since_act_q != '1) begin
                since_act_q <= since_act_q + 1'b1;
            end
            if (done) act_pend_q <= 1'b0;
        end
    end

    p_ready_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !cmd_valid);
    p_pre_act_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_ACT && pre_pend_q) |-> since_pre_q >= SW'(T_RP));
    p_act_col_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op[1] && act_pend_q) |-> since_act_q >= SW'(T_RCD));
    p_done_col_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cmd_valid && cmd_op[1]));
    p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_hit_openpol_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_hit) |-> !closed_pol);
    p_hit_no_act_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_hit) |-> !act_pend_q);
endmodule

// File: tb/sim_dram_cmd_seq.sv
module sim_dram_cmd_seq;
    localparam int ADDR_W = 20, COL_W = 4, BANK_W = 2, TAG_LSB = 10;
    localparam int T_RP = 4, T_RCD = 2;
    localparam int ROW_W = ADDR_W - COL_W - BANK_W;
    localparam int NB = 1 << BANK_W;

    logic clk = 1'b0, rst_n = 1'b0;
    logic closed_pol = 1'b0, req_valid = 1'b0, req_wr = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic req_ready, cmd_valid, cmd_autopre, done, done_hit;
    logic [1:0] cmd_op;
    logic [BANK_W-1:0] cmd_bank;
    logic [ROW_W-1:0] cmd_row;
    logic [COL_W-1:0] cmd_col;

    always #4 clk = ~clk;  // 125 MHz

    dram_cmd_seq #(.ADDR_W(ADDR_W), .COL_W(COL_W), .BANK_W(BANK_W),
                   .TAG_LSB(TAG_LSB), .T_RP(T_RP), .T_RCD(T_RCD)) u0 (
        .clk(clk), .rst_n(rst_n), .closed_pol(closed_pol),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_wr(req_wr), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col),
        .cmd_autopre(cmd_autopre), .done(done), .done_hit(done_hit));

    typedef struct {
        int op; int bank; int row; int col; int ap; int gap; string tag;
    } exp_t;

    exp_t exp_q[$];
    bit   hit_q[$];
    int   checks = 0, fails = 0, cyc = 0;
    bit   m_open[NB];
    int   m_row[NB];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    // Driver: model R3..R8, push expectations, then hand the request over
    task automatic send(input logic [ADDR_W-1:0] a, input bit w);
        int col, row, bank;
        bit hit;
        exp_t e;
        col  = int'(a[COL_W-1:0]);
        row  = int'(a[ADDR_W-1:COL_W+BANK_W]);
        bank = int'(a[COL_W +: BANK_W] ^ a[TAG_LSB +: BANK_W]);  // R3
        hit  = !closed_pol && m_open[bank] && (m_row[bank] == row);
        if (!hit && m_open[bank]) begin  // R5 / R7 leftover
            e = '{0, bank, row, col, 0, 0, "R5"};
            exp_q.push_back(e);
        end
        if (!hit) begin  // R6
            e = '{1, bank, row, col, 0, m_open[bank] ? 1 : 0, "R6"};
            exp_q.push_back(e);
            m_open[bank] = 1'b1;
            m_row[bank]  = row;
        end
        e = '{w ? 3 : 2, bank, row, col, closed_pol ? 1 : 0, hit ? 0 : 2,
              hit ? "R4" : (closed_pol ? "R7" : "R12")};
        exp_q.push_back(e);
        hit_q.push_back(hit);
        if (closed_pol) m_open[bank] = 1'b0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_addr  = a;
        req_wr    = w;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        @(negedge clk);
        while (exp_q.size() != 0 || hit_q.size() != 0 || !req_ready) @(negedge clk);
    endtask

    function automatic logic [ADDR_W-1:0] mk(input int row, input int bf, input int col);
        return {ROW_W'(row), BANK_W'(bf), COL_W'(col)};
    endfunction

    // Monitor / scoreboard
    int last_pre = 0, last_act = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (cmd_valid) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2 unexpected command", int'(cmd_op), -1);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(!req_ready, "R2 ready during command", int'(req_ready), 0);
                    chk(int'(cmd_op) == e.op, {e.tag, " R12 op"}, int'(cmd_op), e.op);
                    chk(int'(cmd_bank) == e.bank, {e.tag, " R3 bank"}, int'(cmd_bank), e.bank);
                    if (e.op == 1)
                        chk(int'(cmd_row) == e.row, {e.tag, " R12 row"}, int'(cmd_row), e.row);
                    if (e.op >= 2) begin
                        chk(int'(cmd_col) == e.col, {e.tag, " R12 col"}, int'(cmd_col), e.col);
                        chk(int'(cmd_autopre) == e.ap, {e.tag, " R7 autopre"}, int'(cmd_autopre), e.ap);
                        chk(done, "R11 done with column", int'(done), 1);
                    end
                    if (e.gap == 1) chk(cyc - last_pre == T_RP, "R9 PRE->ACT", cyc - last_pre, T_RP);
                    if (e.gap == 2) chk(cyc - last_act == T_RCD, "R10 ACT->col", cyc - last_act, T_RCD);
                    if (e.op == 0) last_pre = cyc;
                    if (e.op == 1) last_act = cyc;
                end
            end
            if (done) begin
                if (hit_q.size() == 0) begin
                    chk(1'b0, "R11 unexpected done", 1, 0);
                end else begin
                    bit h;
                    h = hit_q.pop_front();
                    chk(done_hit == h, "R4 done_hit", int'(done_hit), int'(h));
                end
                if (!cmd_valid) chk(1'b0, "R11 done without command", 0, 1);
            end
            if (cyc > 50000) begin
                chk(1'b0, "watchdog", cyc, 50000);
                summary();
            end
        end
    end

    initial begin
        for (int i = 0; i < NB; i++) begin m_open[i] = 1'b0; m_row[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
        chk(cmd_valid == 1'b0, "R1 cmd_valid", int'(cmd_valid), 0);
        chk(done == 1'b0, "R1 done", int'(done), 0);

        // Open-row mode
        send(mk(5, 0, 3), 1'b0);       // R1/R6 miss on closed bank 0
        send(mk(5, 0, 9), 1'b0);       // R4 hit
        send(mk(5, 1, 2), 1'b1);       // bank field 1 -> bank 1, write
        send(mk(16, 0, 7), 1'b1);      // R3: tag bit flips bank field 0 -> bank 1, conflict
        send(mk(5, 0, 1), 1'b0);       // R8: bank 0 still open, hit
        send(mk(6, 0, 4), 1'b0);       // R5: conflict in bank 0
        send(mk(16, 0, 8), 1'b0);      // R8: bank 1 row 16 hit
        send(mk(3, 2, 0), 1'b1);       // bank 2 first use
        drain();

        // R7: closed-row mode, banks 0,1,2 left open
        closed_pol = 1'b1;
        send(mk(6, 0, 5), 1'b0);       // same row but closed policy: PRE ACT RD
        send(mk(6, 0, 5), 1'b0);       // bank released: ACT RD
        send(mk(9, 3, 2), 1'b1);       // ACT WR
        send(mk(9, 3, 2), 1'b1);       // still no hit
        drain();

        // Back to open-row, pseudo-random mix
        closed_pol = 1'b0;
        begin
            logic [31:0] lf;
            lf = 32'h1ACE_B00C;
            for (int n = 0; n < 60; n++) begin
                int r;
                lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
                r  = int'(lf[2:0] % 3) * 17;
                send(mk(r, int'(lf[5:4]), int'(lf[11:8])), lf[12]);
            end
        end
        drain();
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R2 leftover commands", exp_q.size(), 0);
        summary();
    end
endmodule